// File: doc/BRIEF.md
# Serial Framing-Pattern Byte Aligner

This block turns a serial bit stream into bytes and finds where each byte starts. One bit arrives on each cycle where a bit-enable is high. A 48-bit window is compared against the SONET framing word on every bit, so a match can be found at any bit offset. The framing word is three 0xF6 bytes followed by three 0x28 bytes. A divide-by-eight phase counter marks byte boundaries. When a match occurs, the counter restarts at the match position, so the byte boundary and the frame boundary both follow the pattern.

The search is controlled by a downstream framer through an out-of-frame input. While that input is high, every match re-aligns the byte phase and raises a frame pulse for one byte period. When the input is low, matches are ignored and the byte phase stays where it was last set. Each finished byte is presented on a parallel output together with a one-cycle strobe. The strobe is the byte clock, formed inside the block as one enable per eight bit enables.

Top module: `sba_byte_aligner`

## Requirements
- R1: After reset, `byte_out` is 0x00 and `byte_stb` and `frame_pulse` are low. The byte boundary sits at offset zero, so the first byte is built from the first eight accepted bits after reset.
- R2: Bits are packed most significant first. The earliest bit of a byte lands in `byte_out[7]` and the latest in `byte_out[0]`.
- R3: `byte_stb` is high for exactly one clock, the clock after the bit enable that completes a byte. `bit_in` is ignored and state does not advance on cycles where `bit_en` is low.
- R4: While `oof` is high, a match of the 48-bit word 0xF6F6F6282828 ending on any accepted bit completes a byte at that bit. `byte_out` then shows 0x28 with `byte_stb` high, and `frame_pulse` goes high in the same clock.
- R5: `frame_pulse` stays high until the next byte strobe, which is one byte period. If that next strobe comes from a new match, the pulse stays high.
- R6: After a match, later bytes are taken on the new boundary. The next byte completes on the eighth accepted bit after the match, whatever the old phase was.
- R7: While `oof` stays high, each later match raises the frame pulse again and moves the boundary to that match.
- R8: While `oof` is low, matches do not move the boundary and do not raise `frame_pulse`. `frame_pulse` is low from the clock after `oof` is seen low.
- R9: A 48-bit window that differs from the framing word in any bit, including only the last bit, gives no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this clock |
| bit_in | input | 1 | Serial data bit |
| oof | input | 1 | Out-of-frame input; high enables search and re-alignment |
| byte_out | output | 8 | Last assembled byte, MSB first |
| byte_stb | output | 1 | One-clock byte strobe (internal byte clock) |
| frame_pulse | output | 1 | Frame boundary pulse, one byte period long |

## Verification
Some rules are checked by assertions on every cycle:
- the phase counter steps by one, or returns to zero on a match;
- strobes appear only after an accepted bit, and last one clock;
- the frame pulse only rises together with a strobe carrying 0x28, and holds until the next byte;
- the pulse is cleared when `oof` is low.

Other behaviour can only be shown by the bench's scenarios:
- that a match is found at every bit offset;
- that the bytes following a match sit on the new boundary;
- that a pattern sent while `oof` is low leaves the old byte grid in place;
- that a word wrong in only its last bit is rejected.

// File: rtl/sba_pkg.sv
package sba_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] A1_BYTE = 8'hF6;
    localparam logic [BYTE_W-1:0] A2_BYTE = 8'h28;

    typedef struct packed {
        logic              strobe;
        logic              frame;
        logic [BYTE_W-1:0] data;
    } byte_evt_t;

    // Byte idx of the framing word, counted from its first byte.
    function automatic logic [BYTE_W-1:0] pattern_byte(input int idx, input int n_a1);
        return (idx < n_a1) ? A1_BYTE : A2_BYTE;
    endfunction
endpackage

// File: rtl/sba_shift_match.sv
module sba_shift_match #(
    parameter int PAT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic [PAT_W-1:0] pattern_i,
    output logic [7:0]       low_byte,
    output logic             match
);
    // Holds the previous PAT_W-1 bits; the new bit completes the window.
    logic [PAT_W-2:0] hist_q;
    logic [PAT_W-1:0] window;

    assign window   = {hist_q, bit_in};
    assign match    = bit_en && (window == pattern_i);
    assign low_byte = window[7:0];

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (bit_en)
            hist_q <= window[PAT_W-2:0];
    end
endmodule

// File: rtl/sba_phase_ctr.sv
module sba_phase_ctr #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic realign,
    output logic last_bit
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [CW-1:0] cnt_q;

    assign last_bit = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (bit_en) begin
            if (realign || last_bit)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: plain step when no boundary event
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !realign && !last_bit) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R6: a match restarts the phase
    a_r6_realign_zero: assert property (@(posedge clk) disable iff (rst)
        (bit_en && realign) |=> (cnt_q == '0));
    // R3: phase frozen without an accepted bit
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(cnt_q));
endmodule

// File: rtl/sba_byte_emit.sv
module sba_byte_emit
    import sba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_done,
    input  logic              frame_set,
    input  logic              oof,
    input  logic [BYTE_W-1:0] data_in,
    output byte_evt_t         evt
);
    byte_evt_t evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q.strobe <= byte_done;
            if (byte_done)
                evt_q.data <= data_in;
            if (!oof)
                evt_q.frame <= 1'b0;
            else if (byte_done)
                evt_q.frame <= frame_set;
        end
    end

    assign evt = evt_q;

    // R8: no frame pulse once out-of-frame is low
    a_r8_quiet_in_frame: assert property (@(posedge clk) disable iff (rst)
        !oof |=> !evt_q.frame);
    // R5: pulse held until next byte completes
    a_r5_pulse_holds: assert property (@(posedge clk) disable iff (rst)
        (evt_q.frame && oof && !byte_done) |=> evt_q.frame);
    // R3: strobe lasts a single clock
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
        evt_q.strobe |-> $past(byte_done));
endmodule

// File: rtl/sba_byte_aligner.sv
module sba_byte_aligner
    import sba_pkg::*;
#(
    parameter int N_A1 = 3,
    parameter int N_A2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              oof,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_stb,
    output logic              frame_pulse
);
    localparam int N_BYTES = N_A1 + N_A2;
    localparam int PAT_W   = N_BYTES * BYTE_W;

    logic [PAT_W-1:0]  pattern;
    logic [BYTE_W-1:0] low_byte;
    logic              match, realign, last_bit, byte_done;
    byte_evt_t         evt;

    for (genvar i = 0; i < N_BYTES; i++) begin : g_pat
        assign pattern[PAT_W-1-BYTE_W*i -: BYTE_W] = pattern_byte(i, N_A1);
    end

    sba_shift_match #(.PAT_W(PAT_W)) u_match (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .pattern_i(pattern), .low_byte(low_byte), .match(match)
    );

    assign realign   = match && oof;
    assign byte_done = bit_en && (last_bit || realign);

    sba_phase_ctr #(.BYTE_W(BYTE_W)) u_phase (
        .clk(clk), .rst(rst), .bit_en(bit_en), .realign(realign),
        .last_bit(last_bit)
    );

    sba_byte_emit u_emit (
        .clk(clk), .rst(rst), .byte_done(byte_done), .frame_set(realign),
        .oof(oof), .data_in(low_byte), .evt(evt)
    );

    assign byte_out    = evt.data;
    assign byte_stb    = evt.strobe;
    assign frame_pulse = evt.frame;

    // R4: a rising frame pulse comes with a byte strobe
    a_r4_pulse_on_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> byte_stb);
    // R4: the byte shown with the pulse is the last A2 byte
    a_r4_pulse_data: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && byte_stb) |-> (byte_out == A2_BYTE));
    // R3: strobes only follow an accepted bit
    a_r3_strobe_after_bit: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> $past(bit_en));
endmodule

// File: tb/sim_sba_byte_aligner.sv
module sim_sba_byte_aligner;
    localparam logic [47:0] PAT = 48'hF6F6F6282828;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, bit_in = 1'b0, oof = 1'b0;
    logic [7:0] byte_out;
    logic byte_stb, frame_pulse;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 1'b0;

    logic s [0:255];
    int n;
    logic [7:0] hist;
    int ph;
    logic efp;

    always #4 clk = ~clk;

    sba_byte_aligner u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .oof(oof),
        .byte_out(byte_out), .byte_stb(byte_stb), .frame_pulse(frame_pulse)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bit_en = 1'b0; oof = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hist = '0; ph = 0; efp = 1'b0; n = 0;
        @(negedge clk);
        chk("R1", "byte_out", byte_out, 0);
        chk("R1", "byte_stb", byte_stb, 0);
        chk("R1", "frame_pulse", frame_pulse, 0);
    endtask

    task automatic push(input logic [47:0] v, input int w);
        for (int j = w - 1; j >= 0; j--) begin
            s[n] = v[j];
            n++;
        end
    endtask

    // One accepted bit, then an idle cycle with a garbage bit (R3).
    task automatic send_bit(input logic b, input logic es, input logic [7:0] eb,
                            input logic ef, input string tag);
        bit_en = 1'b1; bit_in = b;
        @(negedge clk);
        bit_en = 1'b0; bit_in = ~b;
        chk(tag, "byte_stb", byte_stb, es);
        if (es) chk(tag, "byte_out", byte_out, eb);
        chk(tag, "frame_pulse", frame_pulse, ef);
        @(negedge clk);
        chk("R3", "byte_stb idle", byte_stb, 0);
        chk("R3", "frame_pulse idle", frame_pulse, ef);
    endtask

    // Play s[0..n-1]; m1/m2 are 1-based bit counts where a match ends.
    task automatic run(input int m1, input int m2, input string tag);
        for (int i = 0; i < n; i++) begin
            logic is_m, es;
            hist = {hist[6:0], s[i]};
            ph++;
            is_m = oof && ((i + 1 == m1) || (i + 1 == m2));
            es = is_m || (ph == 8);
            if (es) begin
                ph = 0;
                efp = is_m;
            end
            send_bit(s[i], es, hist, efp, tag);
        end
        n = 0;
    endtask

    task automatic set_oof(input logic v);
        oof = v;
        @(negedge clk);
        if (!v) efp = 1'b0;
        chk("R8", "frame_pulse after oof change", frame_pulse, efp);
    endtask

    initial begin
        @(negedge clk);
        // R1, R2: offset-zero grid, MSB first
        do_reset();
        push(48'hC3, 8); push(48'h5A, 8);
        run(0, 0, "R2");

        // R4, R5, R6: match at every offset in a sweep
        for (int k = 0; k < 12; k++) begin
            do_reset();
            oof = 1'b1;
            push(48'h0, k); push(PAT, 48); push(48'hA5, 8); push(48'h3C, 8);
            run(k + 48, 0, "R4");
        end

        // R7: second match re-aligns again and pulses again
        do_reset();
        oof = 1'b1;
        push(48'h0, 3); push(PAT, 48); push(48'h0, 5); push(PAT, 48); push(48'h81, 8);
        run(51, 104, "R7");

        // R8: drop oof while pulse is high; later pattern off-grid is ignored
        do_reset();
        oof = 1'b1;
        push(48'h0, 3); push(PAT, 48);
        run(51, 0, "R8");
        chk("R8", "pulse before oof drop", frame_pulse, 1);
        set_oof(1'b0);
        push(48'h0, 2); push(PAT, 48); push(48'h0, 6); push(48'h96, 8);
        run(0, 0, "R8");

        // R9: last bit wrong, no match
        do_reset();
        oof = 1'b1;
        push(PAT ^ 48'h1, 48); push(48'h0, 8);
        run(0, 0, "R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule